// File: doc/BRIEF.md
# Rewindable packet write FIFO

This block is a byte buffer that sits between a source delivering bulk packets and a consumer that reads a plain byte stream. The write side accepts the bytes of each packet without looking at them. It stores each byte at a working write pointer. A separate committed head pointer marks how far the reader is allowed to go. When the last byte of a packet arrives with no error, the head pointer jumps forward and the whole packet becomes readable at once.

When the source flags a packet as bad, the working pointer drops back to the head. The partial packet is thrown away and a resent copy lands in the same place. Packets commit back to back with no gaps. A larger unit of data that spans several packets therefore reaches the reader as one unbroken run of bytes.

The capacity is set by the `DEPTH` parameter and must be a power of two. A single packet can commit only if it fits in the whole buffer.

Top module: `pkt_rewind_fifo`

## Requirements
- R1: After reset, `rd_valid` is 0 and `wr_ready` is 1.
- R2: Bytes of a packet stay invisible to the reader until its last byte (`wr_last`=1) is accepted with `wr_err`=0. From the next cycle on, `rd_valid` is 1.
- R3: `wr_ready` is 0 exactly when `DEPTH` bytes are held, counting committed-unread and uncommitted bytes. No byte is accepted while `wr_ready` is 0. A packet of exactly `DEPTH` bytes commits.
- R4: A cycle with `wr_valid`=1 and `wr_err`=1 discards every byte of the packet in progress. The reader never sees those bytes, and the next packet is stored in their place.
- R5: When `wr_err` and `wr_last` are both 1, the packet is discarded, not committed.
- R6: The error flag is taken even while `wr_ready` is 0. The space held by the discarded packet is free again in the next cycle.
- R7: The reader receives committed bytes unchanged and in write order, with consecutive packets joined without gaps.
- R8: `rd_valid` is 0 once every committed byte has been read. A read handshake (`rd_valid`=1 and `rd_ready`=1) advances by exactly one byte.
- R9: Cycles with `wr_valid`=0 store nothing, whatever `wr_data`, `wr_last` and `wr_err` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | DW | Packet byte |
| wr_valid | input | 1 | Write byte or error flag present |
| wr_last | input | 1 | Final byte of the packet |
| wr_err | input | 1 | Discard the packet in progress |
| wr_ready | output | 1 | Space for one more byte |
| rd_data | output | DW | Oldest committed byte |
| rd_valid | output | 1 | A committed byte is available |
| rd_ready | input | 1 | Consumer takes the byte |

## Verification
A bad head pointer shows up at the reader. If it leads the working pointer, uncommitted or discarded bytes appear on `rd_data`. If it lags, a committed packet is held back. The scoreboard sees either fault on the first byte that should or should not arrive.

A working pointer that is not rewound, or that keeps moving while full, leaves the stream shifted, with extra or missing bytes. This causes a miscompare within one packet after the fault. A wrong occupancy count shows within one cycle at `wr_ready` at the full boundary.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

   // Classification of one write-side cycle
   typedef enum logic [1:0] {
      WEV_IDLE   = 2'd0,
      WEV_PUSH   = 2'd1,
      WEV_COMMIT = 2'd2,
      WEV_REWIND = 2'd3
   } wr_event_e;

endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   // Combinational lookahead read: the head byte is always presented
   assign rdata = mem_q[raddr];

endmodule

// File: rtl/pkt_fifo_wr_ctrl.sv
module pkt_fifo_wr_ctrl
   import pkt_fifo_pkg::*;
#(
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic          wr_last,
   input  logic          wr_err,
   input  logic [PW-1:0] rd_ptr,
   output logic          wr_ready,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [PW-1:0] head_ptr
);

   localparam logic [PW-1:0] CAP = PW'(DEPTH);

   logic [PW-1:0] work_ptr;
   logic [PW-1:0] work_nxt;
   logic [PW-1:0] head_nxt;
   logic [PW-1:0] held;
   wr_event_e     ev;

   // Occupancy seen by the writer includes uncommitted bytes
   assign held     = PW'(work_ptr - rd_ptr);
   assign wr_ready = (held != CAP);

   always_comb begin
      if (wr_valid && wr_err) begin
         ev = WEV_REWIND;
      end else if (wr_valid && wr_ready && wr_last) begin
         ev = WEV_COMMIT;
      end else if (wr_valid && wr_ready) begin
         ev = WEV_PUSH;
      end else begin
         ev = WEV_IDLE;
      end
   end

   assign wr_en   = (ev == WEV_PUSH) || (ev == WEV_COMMIT);
   assign wr_addr = work_ptr[AW-1:0];

   always_comb begin
      work_nxt = work_ptr;
      head_nxt = head_ptr;
      unique case (ev)
         WEV_PUSH:   work_nxt = work_ptr + 1'b1;
         WEV_COMMIT: begin
            work_nxt = work_ptr + 1'b1;
            head_nxt = work_ptr + 1'b1;
         end
         WEV_REWIND: work_nxt = head_ptr;
         default:    ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         work_ptr <= '0;
         head_ptr <= '0;
      end else begin
         work_ptr <= work_nxt;
         head_ptr <= head_nxt;
      end
   end

   // R3: writer never holds more than the capacity
   p_no_overflow_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      PW'(work_ptr - rd_ptr) <= CAP);

   // R3: a byte offered while full is not taken
   p_full_blocks_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready && !wr_err) |=> $stable(work_ptr));

   // R4: error returns the working pointer to the committed head
   p_rewind_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_err) |=> (work_ptr == head_ptr) && $stable(head_ptr));

   // R5: error together with last never commits
   p_err_last_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_err && wr_last) |=> $stable(head_ptr));

   // R2: clean last byte moves the head up to the working pointer
   p_commit_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && wr_last && !wr_err)
         |=> (head_ptr == work_ptr) && (head_ptr != $past(head_ptr)));

   // R9: idle cycles change neither pointer
   p_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> $stable(work_ptr) && $stable(head_ptr));

endmodule

// File: rtl/pkt_fifo_rd_ctrl.sv
module pkt_fifo_rd_ctrl #(
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] head_ptr,
   input  logic          rd_ready,
   output logic          rd_valid,
   output logic [PW-1:0] rd_ptr,
   output logic [AW-1:0] rd_addr
);

   // Only committed bytes are exposed to the reader
   assign rd_valid = (head_ptr != rd_ptr);
   assign rd_addr  = rd_ptr[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
      end else if (rd_valid && rd_ready) begin
         rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R8: each handshake advances by exactly one byte
   p_read_step_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready) |=> rd_ptr == PW'($past(rd_ptr) + 1'b1));

   // R8: no handshake, no movement
   p_read_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && rd_ready) |=> $stable(rd_ptr));

endmodule

// File: rtl/pkt_rewind_fifo.sv
module pkt_rewind_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 2048
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_valid,
   input  logic          wr_last,
   input  logic          wr_err,
   output logic          wr_ready,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   input  logic          rd_ready
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] CAP = PW'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pkt_rewind_fifo: DEPTH must be a power of two, at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("pkt_rewind_fifo: DW must be at least 1");
      end
   endgenerate

   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [PW-1:0] head_ptr;
   logic [PW-1:0] rd_ptr;
   logic [AW-1:0] rd_addr;

   pkt_fifo_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_last  (wr_last),
      .wr_err   (wr_err),
      .rd_ptr   (rd_ptr),
      .wr_ready (wr_ready),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .head_ptr (head_ptr)
   );

   pkt_fifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   pkt_fifo_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .head_ptr (head_ptr),
      .rd_ready (rd_ready),
      .rd_valid (rd_valid),
      .rd_ptr   (rd_ptr),
      .rd_addr  (rd_addr)
   );

   // R8: committed data never exceeds capacity, so the reader cannot pass the head
   p_commit_window_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      PW'(head_ptr - rd_ptr) <= CAP);

   // R6: an error while full frees space on the next cycle when nothing is committed
   p_err_frees_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_err && !wr_ready && !rd_valid) |=> wr_ready);

endmodule

// File: tb/test_pkt_rewind_fifo.sv
`timescale 1ns/1ps
module test_pkt_rewind_fifo;

   localparam int DW    = 8;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_valid = 1'b0;
   logic          wr_last = 1'b0;
   logic          wr_err = 1'b0;
   logic          wr_ready;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          rd_ready = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int rd_mode = 0;       // 0 stall, 1 always, 2 random
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] exp_b;

   always #2.5 clk = ~clk;

   pkt_rewind_fifo #(.DW(DW), .DEPTH(DEPTH)) i_pkt_rewind_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_last(wr_last), .wr_err(wr_err),
      .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
   );

   // reader pacing
   always @(posedge clk) begin
      #1;
      case (rd_mode)
         0:       rd_ready = 1'b0;
         1:       rd_ready = 1'b1;
         default: rd_ready = ($urandom_range(0, 2) != 0);
      endcase
   end

   // monitor: R7 scoreboard compare on every read handshake
   always @(negedge clk) begin
      if (rst_n && rd_valid && rd_ready) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R7 unexpected byte act=%h exp=none", rd_data);
         end else begin
            exp_b = exp_q.pop_front();
            if (rd_data !== exp_b) begin
               n_bad++;
               $display("FAIL R7 read data act=%h exp=%h", rd_data, exp_b);
            end
         end
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic sync();
      @(posedge clk);
      #1;
   endtask

   // caller is at posedge+1; returns at posedge+1 after the byte is taken
   task automatic push_byte(logic [DW-1:0] d, bit l, bit e);
      wr_data  = d;
      wr_last  = l;
      wr_err   = e;
      wr_valid = 1'b1;
      @(negedge clk);
      while (!wr_ready && !e) @(negedge clk);
      sync();
      wr_valid = 1'b0;
      wr_last  = 1'b0;
      wr_err   = 1'b0;
   endtask

   task automatic send_pkt(int len, int err_pos);
      logic [DW-1:0] tmp[$];
      for (int i = 0; i < len; i++) begin
         logic [DW-1:0] d;
         d = DW'($urandom);
         push_byte(d, i == len - 1, i == err_pos);
         if (i == err_pos) return;
         tmp.push_back(d);
      end
      foreach (tmp[k]) exp_q.push_back(tmp[k]);
   endtask

   task automatic drain();
      rd_mode = 1;
      repeat (DEPTH + 6) sync();
      rd_mode = 0;
      sync();
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) sync();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd_valid after reset", rd_valid, 0);
      chk("R1 wr_ready after reset", wr_ready, 1);
      sync();

      // R2: invisible until the clean last byte
      push_byte(8'hA0, 0, 0);
      push_byte(8'hA1, 0, 0);
      @(negedge clk);
      chk("R2 rd_valid before last", rd_valid, 0);
      sync();
      push_byte(8'hA2, 1, 0);
      exp_q.push_back(8'hA0); exp_q.push_back(8'hA1); exp_q.push_back(8'hA2);
      @(negedge clk);
      chk("R2 rd_valid after commit", rd_valid, 1);
      sync();

      // R9: idle cycles with noisy controls store nothing
      wr_data = 8'hFF; wr_last = 1'b1; wr_err = 1'b0;
      repeat (3) sync();
      wr_last = 1'b0;
      drain();
      @(negedge clk);
      chk("R8 rd_valid after drain", rd_valid, 0);
      chk("R9 no extra bytes", exp_q.size(), 0);
      sync();

      // R4: errored packet dropped, resend replaces it
      send_pkt(5, 2);
      @(negedge clk);
      chk("R4 rd_valid after error", rd_valid, 0);
      sync();
      send_pkt(5, -1);
      @(negedge clk);
      chk("R4 rd_valid after resend", rd_valid, 1);
      sync();
      drain();

      // R5: error on the last byte rewinds
      send_pkt(4, 3);
      @(negedge clk);
      chk("R5 rd_valid after err+last", rd_valid, 0);
      sync();
      send_pkt(3, -1);
      drain();
      @(negedge clk);
      chk("R5 only good packet read", exp_q.size(), 0);
      sync();

      // R3/R6: fill mid-packet, then rewind
      for (int i = 0; i < DEPTH - 1; i++) push_byte(DW'(i), 0, 0);
      @(negedge clk);
      chk("R3 ready one below full", wr_ready, 1);
      sync();
      push_byte(8'h5A, 0, 0);
      @(negedge clk);
      chk("R3 ready at full", wr_ready, 0);
      sync();
      push_byte(8'h00, 0, 1);
      @(negedge clk);
      chk("R6 ready after rewind while full", wr_ready, 1);
      chk("R6 nothing committed", rd_valid, 0);
      sync();
      send_pkt(DEPTH, -1);
      @(negedge clk);
      chk("R3 full-size packet committed", rd_valid, 1);
      chk("R3 ready at full commit", wr_ready, 0);
      sync();
      drain();
      @(negedge clk);
      chk("R3 ready after drain", wr_ready, 1);
      sync();

      // R7: random traffic with random errors and reader stalls
      rd_mode = 2;
      for (int p = 0; p < 300; p++) begin
         int len;
         int ep;
         len = $urandom_range(1, 12);
         ep  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, len - 1) : -1;
         send_pkt(len, ep);
      end
      drain();
      @(negedge clk);
      chk("R7 all committed bytes read", exp_q.size(), 0);
      chk("R8 rd_valid at end", rd_valid, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule